// File: doc/BRIEF.md
# Programmable-Priority Vectored Interrupt Controller

This block gathers interrupt requests from 29 peripheral sources (four serial channels, two serial management channels, four timers, twelve port pins, DMA engines, SPI, I2C and a parallel port) into one request line toward an upstream interrupt controller. Each source owns one fixed bit position in three 32-bit registers: pending, mask and in-service. A source competes for service when its pending and mask bits are both set, and the line is raised only if the winner outranks everything already in service and the global enable is on. The line carries a programmable 3-bit level alongside it.

Software shapes the ranking through one configuration word. Four 2-bit slot fields place the serial channels in order relative to each other, a scheme bit decides whether those channels are grouped at the top of the fixed order or spread through it, and a 5-bit field lifts any one source above all others. Software acknowledges by writing a one to the acknowledge bit of the vector register; the block then captures the winning source's vector, clears its pending bit and marks it in service. In-service bits are released by writing ones to them.

Source bit positions (and vector numbers): bits 0, 12 and 20 are unused; serial channels 1 to 4 sit at bits 27 to 30; all other bits from 1 to 31 are the remaining 25 sources.

Top module: `pvic_top`

## Requirements
- R1: After reset the configuration, pending, mask, in-service and vector registers all read zero and the request output is low.
- R2: A source input that is high at a clock edge sets its pending bit; bits 0, 12 and 20 of the pending (address 1), mask and in-service registers always read zero.
- R3: The request output is high exactly when the enable bit (configuration bit 3) is set and some source with pending and mask set outranks every in-service source; the level output always shows configuration bits [2:0].
- R4: Writing a word with bit 8 set to address 4 captures the winner's bit index into vector bits [4:0], clears its pending bit and sets its in-service bit.
- R5: An acknowledge with no qualifying source returns vector 0 and leaves pending and in-service unchanged.
- R6: Configuration fields [11:10], [13:12], [15:14], [17:16] are serial slots 0 (highest) to 3 (lowest); each holds a channel code 00..11 naming channel 1..4 at bit 27 + code.
- R7: With the scheme bit (configuration bit 4) at 0 the ranking is slot 0..3, then the other sources in descending bit order.
- R8: With the scheme bit at 1, slot k sits at rank 7k (ranks 0, 7, 14, 21) and the other sources fill the remaining ranks 1..28 in descending bit order.
- R9: Configuration field [9:5] names one bit index whose source outranks all others; the value 0 promotes nothing.
- R10: Writing to the in-service register (address 3) clears every bit written as one and leaves the rest.
- R11: The mask register (address 2) is read/write; a source with its mask bit clear never qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 32 | Per-bit source request lines |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 config, 1 pending, 2 mask, 3 in-service, 4 vector) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_req | output | 1 | Request to upstream controller |
| irq_level | output | 3 | Programmed request level |

## Verification
The ordering is swept over all 24 slot permutations under both schemes with every source pending, and the full acknowledge sequence is compared against an ordering list built in the bench, which separates slot decoding, grouped placement and spread placement. Targeted patterns then split apart the qualification terms: the same pending set with enable off versus on, with mask cleared, and with a higher or lower source already in service. A promoted low-index source is checked to win first and then hand over to the normal order, and an acknowledge with nothing qualifying is checked to return the zero vector without disturbing state.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    localparam int NBITS     = 32;
    localparam int IDXW      = $clog2(NBITS);
    localparam int KEYW      = IDXW + 1;
    localparam int NSER      = 4;
    localparam int SER_BASE  = 27;
    localparam int SPREAD    = 7;
    localparam int LAST_RANK = 28;
    localparam logic [NBITS-1:0] SRC_VALID = 32'hFFEF_EFFE;

    typedef struct packed {
        logic [1:0]      slot3;
        logic [1:0]      slot2;
        logic [1:0]      slot1;
        logic [1:0]      slot0;
        logic [IDXW-1:0] promote;
        logic            scheme;
        logic            en;
        logic [2:0]      level;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic bit is_serial(int b);
        return (b >= SER_BASE) && (b < SER_BASE + NSER);
    endfunction

    // position of a non-serial source among non-serial sources, 0 = highest
    function automatic int ns_order(int b);
        int n = 0;
        for (int i = NBITS - 1; i > b; i--) begin
            if (SRC_VALID[i] && !is_serial(i)) n++;
        end
        return n;
    endfunction

    function automatic int ns_rank(int j, bit spread);
        int gap;
        gap = j / (SPREAD - 1);
        if (gap > NSER - 1) gap = NSER - 1;
        return spread ? (j + gap + 1) : (j + NSER);
    endfunction
endpackage

// File: rtl/pvic_rank_map.sv
module pvic_rank_map
    import pvic_pkg::*;
(
    input  logic [NSER-1:0][1:0]      slots,
    input  logic                      scheme,
    input  logic [IDXW-1:0]           promote,
    output logic [NBITS-1:0][KEYW-1:0] key
);
    localparam logic [KEYW-1:0] TOP_KEY  = KEYW'(NBITS);
    localparam int              KEY_BASE = NBITS - 1;

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        if (!SRC_VALID[b]) begin : g_unused
            assign key[b] = '0;
        end else if (is_serial(b)) begin : g_ser
            localparam logic [1:0] CODE = 2'(b - SER_BASE);
            int rank;
            always_comb begin
                rank = LAST_RANK;
                for (int k = NSER - 1; k >= 0; k--) begin
                    if (slots[k] == CODE) rank = scheme ? k * SPREAD : k;
                end
            end
            assign key[b] = (promote == IDXW'(b)) ? TOP_KEY
                                                  : KEYW'(KEY_BASE - rank);
        end else begin : g_fixed
            localparam int ORD = ns_order(b);
            localparam logic [KEYW-1:0] K_GROUP  = KEYW'(KEY_BASE - ns_rank(ORD, 1'b0));
            localparam logic [KEYW-1:0] K_SPREAD = KEYW'(KEY_BASE - ns_rank(ORD, 1'b1));
            assign key[b] = (promote == IDXW'(b)) ? TOP_KEY
                          : (scheme ? K_SPREAD : K_GROUP);
        end
    end
endmodule

// File: rtl/pvic_pick.sv
module pvic_pick
    import pvic_pkg::*;
(
    input  logic [NBITS-1:0]           req,
    input  logic [NBITS-1:0][KEYW-1:0] key,
    output logic                       found,
    output logic [IDXW-1:0]            idx,
    output logic [KEYW-1:0]            best
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int b = 0; b < NBITS; b++) begin
            if (req[b] && (key[b] > best)) begin
                found = 1'b1;
                idx   = IDXW'(b);
                best  = key[b];
            end
        end
    end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] src_req,
    input  logic        bus_wr_en,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_req,
    output logic [2:0]  irq_level
);
    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_PEND = 3'd1;
    localparam logic [2:0] A_MASK = 3'd2;
    localparam logic [2:0] A_SVC  = 3'd3;
    localparam logic [2:0] A_VEC  = 3'd4;
    localparam int         ACK_BIT = 8;

    typedef struct packed {
        cfg_t             cfg;
        logic [NBITS-1:0] pend;
        logic [NBITS-1:0] mask;
        logic [NBITS-1:0] insvc;
        logic [IDXW-1:0]  vec;
    } state_t;

    state_t st_d, st_q;

    logic [NBITS-1:0][KEYW-1:0] key;
    logic                       win_found, svc_found, qualified;
    logic [IDXW-1:0]            win_idx, svc_idx;
    logic [KEYW-1:0]            win_key, svc_key;

    pvic_rank_map u_rank (
        .slots   ({st_q.cfg.slot3, st_q.cfg.slot2, st_q.cfg.slot1, st_q.cfg.slot0}),
        .scheme  (st_q.cfg.scheme),
        .promote (st_q.cfg.promote),
        .key     (key)
    );

    pvic_pick u_pick_win (
        .req   (st_q.pend & st_q.mask),
        .key   (key),
        .found (win_found),
        .idx   (win_idx),
        .best  (win_key)
    );

    pvic_pick u_pick_svc (
        .req   (st_q.insvc),
        .key   (key),
        .found (svc_found),
        .idx   (svc_idx),
        .best  (svc_key)
    );

    assign qualified = win_found && (!svc_found || (win_key > svc_key));
    assign irq_req   = st_q.cfg.en && qualified;
    assign irq_level = st_q.cfg.level;

    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.pend | (src_req & SRC_VALID);
        if (bus_wr_en) begin
            unique case (bus_addr)
                A_CFG:  st_d.cfg   = cfg_t'(bus_wdata[CFG_W-1:0]);
                A_MASK: st_d.mask  = bus_wdata & SRC_VALID;
                A_SVC:  st_d.insvc = st_q.insvc & ~bus_wdata;
                A_VEC: begin
                    if (bus_wdata[ACK_BIT]) begin
                        if (qualified) begin
                            st_d.vec            = win_idx;
                            st_d.pend[win_idx]  = 1'b0;
                            st_d.insvc[win_idx] = 1'b1;
                        end else begin
                            st_d.vec = '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            A_CFG:   bus_rdata = {{(32-CFG_W){1'b0}}, st_q.cfg};
            A_PEND:  bus_rdata = st_q.pend;
            A_MASK:  bus_rdata = st_q.mask;
            A_SVC:   bus_rdata = st_q.insvc;
            A_VEC:   bus_rdata = {{(32-IDXW){1'b0}}, st_q.vec};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker
    import pvic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic             cfg_en,
    input logic             bus_wr_en,
    input logic [2:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [NBITS-1:0] pend,
    input logic [NBITS-1:0] mask,
    input logic [NBITS-1:0] insvc,
    input logic [IDXW-1:0]  vec,
    input logic             qualified,
    input logic [IDXW-1:0]  win_idx
);
    logic ack_wr;
    assign ack_wr = bus_wr_en && (bus_addr == 3'd4) && bus_wdata[8];

    assert_req_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (cfg_en && |(pend & mask)));

    assert_winner_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        qualified |-> (pend[win_idx] && mask[win_idx]));

    assert_ack_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && qualified) |=> (insvc[$past(win_idx)] && !pend[$past(win_idx)]));

    assert_ack_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && qualified) |=> ((vec != '0) && SRC_VALID[vec]));

    assert_error_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !qualified) |=> (vec == '0));

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend | mask | insvc) & ~SRC_VALID) == '0));
endmodule

bind pvic_top pvic_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .cfg_en    (st_q.cfg.en),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend      (st_q.pend),
    .mask      (st_q.mask),
    .insvc     (st_q.insvc),
    .vec       (st_q.vec),
    .qualified (qualified),
    .win_idx   (win_idx)
);

// File: tb/pvic_top_tb.sv
module pvic_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic        bus_wr_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [2:0]  irq_level;

    int n_tests = 0;
    int n_fail  = 0;

    pvic_top u_dut (.*);

    always #10 clk = ~clk;

    localparam logic [31:0] USED = ~((32'd1 << 0) | (32'd1 << 12) | (32'd1 << 20));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk); src_req = v;
        @(negedge clk); src_req = '0;
    endtask

    function automatic logic [31:0] cfgw(input int lvl, input bit en, input bit sch,
                                         input int prom, input int s0, input int s1,
                                         input int s2, input int s3);
        return 32'(lvl) | (32'(en) << 3) | (32'(sch) << 4) | (32'(prom) << 5) |
               (32'(s0) << 10) | (32'(s1) << 12) | (32'(s2) << 14) | (32'(s3) << 16);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        int          ns_list[25];
        int          nn;
        nn = 0;
        for (int b = 31; b >= 1; b--) begin
            if (USED[b] && !(b >= 27 && b <= 30)) begin
                ns_list[nn] = b; nn++;
            end
        end

        do_reset();
        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), r);
            check(r == 0, "R1", $sformatf("reg %0d after reset", a), r, 0);
        end
        check(irq_req == 1'b0, "R1", "request after reset", 32'(irq_req), 0);

        // R2 / R11 unused bits, mask read back, pending capture
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, r);
        check(r == USED, "R11", "mask readback", r, USED);
        pulse(32'hFFFF_FFFF);
        rd(3'd1, r);
        check(r == USED, "R2", "pending capture", r, USED);

        // R3 enable gating and level
        check(irq_req == 1'b0, "R3", "request with enable off", 32'(irq_req), 0);
        wr(3'd0, cfgw(5, 1, 0, 0, 0, 1, 2, 3));
        #1;
        check(irq_req == 1'b1, "R3", "request with enable on", 32'(irq_req), 1);
        check(irq_level == 3'd5, "R3", "level output", 32'(irq_level), 5);

        // R11 / R5 masked sources do not qualify
        wr(3'd2, 32'h0);
        #1;
        check(irq_req == 1'b0, "R11", "request with mask clear", 32'(irq_req), 0);
        wr(3'd4, 32'h100);
        rd(3'd4, r);
        check(r == 0, "R5", "error vector", r, 0);
        rd(3'd1, r);
        check(r == USED, "R5", "pending unchanged after error ack", r, USED);
        rd(3'd3, r);
        check(r == 0, "R5", "in-service unchanged after error ack", r, 0);

        // R3 / R4 / R10 in-service blocking
        do_reset();
        wr(3'd0, cfgw(2, 1, 0, 0, 0, 1, 2, 3));
        wr(3'd2, 32'hFFFF_FFFF);
        pulse(32'd1 << 5);
        wr(3'd4, 32'h100);
        rd(3'd4, r);
        check(r == 5, "R4", "vector of single source", r, 5);
        rd(3'd3, r);
        check(r == (32'd1 << 5), "R4", "in-service set on ack", r, 32'd1 << 5);
        rd(3'd1, r);
        check(r == 0, "R4", "pending cleared on ack", r, 0);
        pulse(32'd1 << 3);
        #1;
        check(irq_req == 1'b0, "R3", "lower source blocked by in-service", 32'(irq_req), 0);
        pulse(32'd1 << 27);
        #1;
        check(irq_req == 1'b1, "R3", "higher source passes in-service", 32'(irq_req), 1);
        wr(3'd3, 32'd1 << 5);
        rd(3'd3, r);
        check(r == 0, "R10", "write-one clear of in-service", r, 0);

        // R9 promotion
        do_reset();
        wr(3'd0, cfgw(1, 1, 0, 1, 0, 1, 2, 3));
        wr(3'd2, 32'hFFFF_FFFF);
        pulse(32'hFFFF_FFFF);
        wr(3'd4, 32'h100);
        rd(3'd4, r);
        check(r == 1, "R9", "promoted source wins", r, 1);
        wr(3'd3, 32'd1 << 1);
        wr(3'd4, 32'h100);
        rd(3'd4, r);
        check(r == 27, "R9", "order after promoted source", r, 27);

        // R6 / R7 / R8 / R4 exhaustive slot permutations, both schemes
        for (int sch = 0; sch < 2; sch++) begin
            for (int a = 0; a < 4; a++) for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++) for (int d = 0; d < 4; d++) begin
                int  slot[4];
                int  exp_list[29];
                int  ni;
                bit  ok;
                logic [31:0] got_bad, exp_bad;
                if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
                slot[0] = a; slot[1] = b; slot[2] = c; slot[3] = d;
                ni = 0;
                for (int p = 0; p < 29; p++) begin
                    if (sch == 0 && p < 4)                     exp_list[p] = 27 + slot[p];
                    else if (sch == 1 && p % 7 == 0 && p <= 21) exp_list[p] = 27 + slot[p / 7];
                    else begin exp_list[p] = ns_list[ni]; ni++; end
                end
                do_reset();
                wr(3'd0, cfgw(3, 1, sch[0], 0, a, b, c, d));
                wr(3'd2, 32'hFFFF_FFFF);
                pulse(32'hFFFF_FFFF);
                ok = 1'b1; got_bad = '0; exp_bad = '0;
                for (int i = 0; i < 29; i++) begin
                    wr(3'd4, 32'h100);
                    rd(3'd4, r);
                    if (ok && r != 32'(exp_list[i])) begin
                        ok = 1'b0; got_bad = r; exp_bad = 32'(exp_list[i]);
                    end
                    wr(3'd3, 32'd1 << r[4:0]);
                end
                check(ok, sch ? "R8" : "R7",
                      $sformatf("R6 order slots %0d%0d%0d%0d scheme %0d", a, b, c, d, sch),
                      got_bad, exp_bad);
                wr(3'd4, 32'h100);
                rd(3'd4, r);
                check(r == 0, "R5", "vector after all served", r, 0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule